// File: doc/BRIEF.md
# Mixed-Decay Fixed Off-Time Controller

This block is the digital timing core of one H-bridge current regulator. While driving, it turns on one diagonal pair of the bridge, chosen by the direction input. A current-sense comparator trip ends the drive phase, but only once a blanking window after each controller-initiated switch has expired. The trip starts an off-time of fixed length. The off-time opens with an all-off crossover gap, then runs fast decay with the opposite diagonal conducting, then a forced all-off dead gap, then slow decay with both low-side devices on. When the off-time ends, the controller inserts another crossover gap and drives again.

Recirculation is synchronous. A zero-current flag seen during the off-time switches every device off for the rest of that off-time, so the load current cannot reverse. A change of direction while driving restarts the cycle on the other diagonal after a crossover gap. With enable low, the bridge coasts.

All durations are set in nanoseconds and converted to whole clock cycles from a clock-frequency parameter, rounding to the nearest cycle. At the default 50 MHz, the conversion gives these counts:

| Duration | Cycles |
|---|---|
| Off-time | 405 |
| Fast decay ends at off-time cycle | 122 |
| Dead gap | 30 |
| Crossover gap | 25 |
| Blanking window | 50 |

Top module: `mdc_ctrl`

## Requirements
- R1: In reset, and one cycle after enable is sampled low in any state, all four gate outputs are 0 and the phase output reads coast.
- R2: Gate bit 3 is leg A high side, bit 2 is leg A low side, bit 1 is leg B high side and bit 0 is leg B low side. Drive with direction 1 gives 4'b1001, and drive with direction 0 gives 4'b0110. A leg never has both of its devices on.
- R3: Before every drive phase, whether entered from coast or from the end of an off-time, there are exactly the crossover-gap number of cycles (25 by default) with all gates off and phase reading gap.
- R4: During the first blanking-window cycles of each drive phase (50 by default), the blank output is 1 and a trip is ignored. With trip held high, drive therefore lasts exactly 51 cycles. After the window, a trip ends drive on the next edge.
- R5: An off-time lasts a fixed number of cycles counted from its first cycle (405 by default). Off-time cycles 0 to 24 are an all-off gap. Cycles 25 to 121 are fast decay, with the opposite diagonal on. Cycles 122 to 151 are an all-off dead gap. Cycles 152 to 404 are slow decay, with 4'b0101.
- R6: A zero-current flag sampled high during an off-time forces all gates to 0 from the next cycle until that off-time ends, even if the flag then falls. The flag has no effect while driving.
- R7: A direction change sampled during drive moves the block to the gap phase on the next cycle. After the crossover gap, drive resumes on the other diagonal.
- R8: The phase output reads 0 for coast, 1 for gap (crossover or dead gap), 2 for drive, 3 for fast decay and 4 for slow decay.
- R9: Cycle counts are computed as round(CLK_HZ × ns / 1e9). The fast-decay end is round(off-time cycles × FAST_PERMIL / 1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Bridge enable; low forces coast |
| dir_i | input | 1 | Direction; selects the drive diagonal |
| trip_i | input | 1 | Current-sense comparator trip, synchronous |
| zero_i | input | 1 | Zero load-current flag, synchronous |
| gate_o | output | 4 | Gate enables {A high, A low, B high, B low} |
| phase_o | output | 3 | Current phase code (see R8) |
| blank_o | output | 1 | High while the trip input is blanked in drive |

## Verification
The assertions assume that enable, direction, trip and zero flags are already synchronous to the clock and stable around the active edge. They also assume that the gate pattern visible in drive reflects the direction latched at drive entry. The bench meets these conditions by changing every input shortly after a rising edge and sampling outputs a few nanoseconds later. It raises the zero flag for one cycle only, at chosen off-time indices in the gap, fast and slow parts, so that stickiness is exercised. It drops enable only once a phase has been observed on the outputs.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

   typedef enum logic [2:0] {
      PH_COAST = 3'd0,
      PH_GAP   = 3'd1,
      PH_DRIVE = 3'd2,
      PH_FAST  = 3'd3,
      PH_SLOW  = 3'd4
   } mdc_phase_e;

   typedef enum logic [1:0] {
      ST_COAST,
      ST_XGAP,
      ST_DRIVE,
      ST_OFF
   } mdc_state_e;

   // nanoseconds to whole clock cycles, rounded to nearest
   function automatic longint ns_to_cyc(input longint hz, input longint ns);
      return (hz * ns + 64'd500_000_000) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/mdc_cnt.sv
module mdc_cnt #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  q_o <= '0;
      else if (clr_i)              q_o <= '0;
      else if (inc_i && q_o != TOP) q_o <= q_o + 1'b1;
   end
endmodule

// File: rtl/mdc_off_decode.sv
module mdc_off_decode import mdc_pkg::*; #(
   parameter int W        = 9,
   parameter int XOV_CYC  = 25,
   parameter int FAST_END = 122,
   parameter int DEAD_END = 152,
   parameter int OFF_CYC  = 405
) (
   input  logic [W-1:0] cnt_i,
   output mdc_phase_e   sub_o,
   output logic         last_o
);
   localparam logic [W-1:0] XOV_C  = W'(XOV_CYC);
   localparam logic [W-1:0] FAST_C = W'(FAST_END);
   localparam logic [W-1:0] DEAD_C = W'(DEAD_END);
   localparam logic [W-1:0] LAST_C = W'(OFF_CYC - 1);

   always_comb begin
      if (cnt_i < XOV_C)       sub_o = PH_GAP;
      else if (cnt_i < FAST_C) sub_o = PH_FAST;
      else if (cnt_i < DEAD_C) sub_o = PH_GAP;
      else                     sub_o = PH_SLOW;
   end

   assign last_o = (cnt_i == LAST_C);
endmodule

// File: rtl/mdc_gate_map.sv
module mdc_gate_map import mdc_pkg::*; #(
   parameter bit SLOW_HIGH = 1'b0
) (
   input  mdc_phase_e  phase_i,
   input  logic        dir_i,
   input  logic        zc_i,
   output logic [3:0]  gate_o
);
   logic [3:0] slow_pat;
   logic [3:0] drv_pat;
   logic [3:0] fast_pat;

   generate
      if (SLOW_HIGH) begin : g_slow_hi
         assign slow_pat = 4'b1010;
      end else begin : g_slow_lo
         assign slow_pat = 4'b0101;
      end
   endgenerate

   assign drv_pat  = dir_i ? 4'b1001 : 4'b0110;
   assign fast_pat = dir_i ? 4'b0110 : 4'b1001;

   always_comb begin
      unique case (phase_i)
         PH_DRIVE: gate_o = drv_pat;
         PH_FAST:  gate_o = zc_i ? 4'b0000 : fast_pat;
         PH_SLOW:  gate_o = zc_i ? 4'b0000 : slow_pat;
         default:  gate_o = 4'b0000;
      endcase
   end
endmodule

// File: rtl/mdc_ctrl.sv
module mdc_ctrl import mdc_pkg::*; #(
   parameter longint CLK_HZ      = 50_000_000,
   parameter int     OFF_NS      = 8100,
   parameter int     FAST_PERMIL = 301,
   parameter int     DEAD_NS     = 600,
   parameter int     XOV_NS      = 500,
   parameter int     BLANK_NS    = 1000,
   parameter bit     SLOW_HIGH   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       dir_i,
   input  logic       trip_i,
   input  logic       zero_i,
   output logic [3:0] gate_o,
   output logic [2:0] phase_o,
   output logic       blank_o
);
   localparam int OFF_CYC   = int'(ns_to_cyc(CLK_HZ, longint'(OFF_NS)));
   localparam int DEAD_CYC  = int'(ns_to_cyc(CLK_HZ, longint'(DEAD_NS)));
   localparam int XOV_CYC   = int'(ns_to_cyc(CLK_HZ, longint'(XOV_NS)));
   localparam int BLANK_CYC = int'(ns_to_cyc(CLK_HZ, longint'(BLANK_NS)));
   localparam int FAST_END  = (OFF_CYC * FAST_PERMIL + 500) / 1000;
   localparam int DEAD_END  = FAST_END + DEAD_CYC;
   localparam int CNT_W     = $clog2(OFF_CYC + 1);

   localparam logic [CNT_W-1:0] XOV_LAST_C = CNT_W'(XOV_CYC - 1);
   localparam logic [CNT_W-1:0] BLANK_C    = CNT_W'(BLANK_CYC);

   generate
      if (XOV_CYC < 1) begin : g_bad_xov
         $error("crossover gap must be at least one cycle");
      end
      if (XOV_CYC >= FAST_END) begin : g_bad_fast
         $error("fast decay must outlast the crossover gap");
      end
      if (DEAD_END >= OFF_CYC) begin : g_bad_dead
         $error("dead gap must end before the off-time");
      end
      if (BLANK_CYC >= OFF_CYC) begin : g_bad_blank
         $error("blanking window must fit the counter");
      end
      if (FAST_PERMIL < 1 || FAST_PERMIL > 999) begin : g_bad_permil
         $error("fast decay share out of range");
      end
   endgenerate

   mdc_state_e       state_q, state_d;
   logic             dir_q, dir_d;
   logic             zc_q;
   logic             cnt_clr, cnt_inc;
   logic [CNT_W-1:0] cnt;
   mdc_phase_e       sub_ph, phase;
   logic             off_last;
   logic             blanked;

   mdc_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .inc_i (cnt_inc),
      .q_o   (cnt)
   );

   mdc_off_decode #(
      .W        (CNT_W),
      .XOV_CYC  (XOV_CYC),
      .FAST_END (FAST_END),
      .DEAD_END (DEAD_END),
      .OFF_CYC  (OFF_CYC)
   ) u_dec (
      .cnt_i  (cnt),
      .sub_o  (sub_ph),
      .last_o (off_last)
   );

   assign blanked = (state_q == ST_DRIVE) && (cnt < BLANK_C);

   always_comb begin
      state_d = state_q;
      dir_d   = dir_q;
      cnt_clr = 1'b0;
      cnt_inc = 1'b1;
      unique case (state_q)
         ST_COAST: begin
            cnt_inc = 1'b0;
            if (en_i) begin
               state_d = ST_XGAP;
               dir_d   = dir_i;
               cnt_clr = 1'b1;
            end
         end
         ST_XGAP: begin
            if (cnt == XOV_LAST_C) begin
               state_d = ST_DRIVE;
               cnt_clr = 1'b1;
            end
         end
         ST_DRIVE: begin
            cnt_inc = blanked;
            if (dir_i != dir_q) begin
               state_d = ST_XGAP;
               dir_d   = dir_i;
               cnt_clr = 1'b1;
            end else if (trip_i && !blanked) begin
               state_d = ST_OFF;
               cnt_clr = 1'b1;
            end
         end
         ST_OFF: begin
            if (off_last) begin
               state_d = ST_XGAP;
               dir_d   = dir_i;
               cnt_clr = 1'b1;
            end
         end
         default: state_d = ST_COAST;
      endcase
      if (!en_i) begin
         state_d = ST_COAST;
         cnt_clr = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_COAST;
         dir_q   <= 1'b0;
         zc_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         dir_q   <= dir_d;
         if (state_q != ST_OFF) zc_q <= 1'b0;
         else if (zero_i)       zc_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_COAST: phase = PH_COAST;
         ST_XGAP:  phase = PH_GAP;
         ST_DRIVE: phase = PH_DRIVE;
         default:  phase = sub_ph;
      endcase
   end

   mdc_gate_map #(.SLOW_HIGH(SLOW_HIGH)) u_map (
      .phase_i (phase),
      .dir_i   (dir_q),
      .zc_i    (zc_q),
      .gate_o  (gate_o)
   );

   assign phase_o = phase;
   assign blank_o = blanked;
endmodule

// File: rtl/mdc_ctrl_chk.sv
module mdc_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic       dir_i,
   input logic       zero_i,
   input logic [3:0] gate_o,
   input logic [2:0] phase_o,
   input logic       blank_o
);
   logic [3:0] drv_exp;
   assign drv_exp = dir_i ? 4'b1001 : 4'b0110;

   p_coast_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (gate_o == 4'b0000 && phase_o == 3'd0));

   p_leg_safe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[3] && gate_o[2]) && !(gate_o[1] && gate_o[0]));

   p_drive_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd2) |-> (gate_o == 4'b1001 || gate_o == 4'b0110));

   p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_o && en_i && gate_o == drv_exp) |=> (phase_o == 3'd2));

   p_fast_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd3) |=> (phase_o == 3'd3 || phase_o == 3'd1 || phase_o == 3'd0));

   p_slow_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd4) |=> (phase_o == 3'd4 || phase_o == 3'd1 || phase_o == 3'd0));

   p_zero_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_o == 3'd3 || phase_o == 3'd4) && zero_i) |=> (gate_o == 4'b0000));

   p_dir_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd2 && en_i && gate_o != drv_exp) |=> (phase_o == 3'd1));
endmodule

bind mdc_ctrl mdc_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_i    (en_i),
   .dir_i   (dir_i),
   .zero_i  (zero_i),
   .gate_o  (gate_o),
   .phase_o (phase_o),
   .blank_o (blank_o)
);

// File: tb/mdc_ctrl_tb_top.sv
module mdc_ctrl_tb_top;
   localparam int XOV      = 25;
   localparam int BLANK    = 50;
   localparam int OFF      = 405;
   localparam int FAST_END = 122;
   localparam int DEAD_END = 152;
   localparam int NV       = 5;
   localparam bit VDIR [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam int VZERO[NV] = '{-1, -1, 60, 200, 10};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, dir = 1'b0, trip = 1'b0, zero = 1'b0;
   logic [3:0] gate;
   logic [2:0] phase;
   logic       blank;
   int         n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   mdc_ctrl dut_i (
      .clk (clk), .rst_n (rst_n), .en_i (en), .dir_i (dir),
      .trip_i (trip), .zero_i (zero),
      .gate_o (gate), .phase_o (phase), .blank_o (blank)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic count_while(input int p, output int n);
      n = 0;
      while (phase == 3'(p) && n < 2000) begin
         n++;
         tick();
      end
   endtask

   function automatic int exp_phase(input int c);
      if (c < XOV)      return 1;
      if (c < FAST_END) return 3;
      if (c < DEAD_END) return 1;
      if (c < OFF)      return 4;
      return 1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int n, bad_ph, bad_g, ep, eg, z;
      logic [3:0] drv, fst;
      // R1: reset state
      tick(); tick();
      chk("R1 reset gates", gate, 0);
      chk("R1/R8 reset phase", phase, 0);
      chk("R1 reset blank", blank, 0);
      rst_n = 1'b1;
      tick();

      // vector walk: R2 R3 R4 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         en = 1'b0; trip = 1'b0; zero = 1'b0;
         tick();
         dir = VDIR[v]; en = 1'b1; trip = 1'b1;
         z = VZERO[v];
         drv = dir ? 4'b1001 : 4'b0110;
         fst = dir ? 4'b0110 : 4'b1001;
         tick();
         count_while(1, n);
         chk("R3/R9 entry gap length", n, XOV);
         bad_g = 0;
         n = 0;
         while (phase == 3'd2 && n < 2000) begin
            if (gate != drv) bad_g++;
            n++;
            tick();
         end
         chk("R4 drive length with trip held", n, BLANK + 1);
         chk("R2 drive gates", bad_g, 0);
         bad_ph = 0; bad_g = 0;
         for (int c = 0; c < OFF + XOV; c++) begin
            ep = exp_phase(c);
            if (ep == 3)      eg = (z >= 0 && c > z) ? 0 : int'(fst);
            else if (ep == 4) eg = (z >= 0 && c > z) ? 0 : 5;
            else              eg = 0;
            if (int'(phase) != ep) bad_ph++;
            if (int'(gate) != eg) bad_g++;
            if (c == z) zero = 1'b1;
            if (c == z + 1) zero = 1'b0;
            tick();
         end
         chk("R5/R8 off-time phase sequence", bad_ph, 0);
         chk(z >= 0 ? "R6 zero-cut gates" : "R5 decay gates", bad_g, 0);
         chk("R5 drive after off-time", phase, 2);
      end

      // R4: blanking window, short trip ignored, R6 zero ignored in drive
      en = 1'b0; trip = 1'b0; tick();
      dir = 1'b1; en = 1'b1; tick();
      count_while(1, n);
      chk("R4 blank at drive start", blank, 1);
      repeat (10) tick();
      trip = 1'b1; tick(); trip = 1'b0;
      tick(); tick();
      chk("R4 trip in blank ignored", phase, 2);
      repeat (36) tick();
      chk("R4 blank at last blanked cycle", blank, 1);
      tick();
      chk("R4 blank ends", blank, 0);
      zero = 1'b1; tick(); tick(); zero = 1'b0;
      chk("R6 zero in drive ignored", gate, 4'b1001);
      trip = 1'b1; tick(); trip = 1'b0;
      chk("R4 trip after blank accepted", phase, 1);
      chk("R4 gates off after trip", gate, 0);

      // R7: direction change during drive
      en = 1'b0; tick();
      dir = 1'b1; en = 1'b1; tick();
      count_while(1, n);
      repeat (5) tick();
      dir = 1'b0; tick();
      chk("R7 gap after direction change", phase, 1);
      count_while(1, n);
      chk("R7/R3 gap length after direction change", n, XOV);
      chk("R7 other diagonal", gate, 4'b0110);

      // R1: enable low in drive and in decay
      en = 1'b0; tick();
      chk("R1 coast from drive gates", gate, 0);
      chk("R1 coast from drive phase", phase, 0);
      dir = 1'b0; en = 1'b1; trip = 1'b1; tick();
      n = 0;
      while (phase != 3'd3 && n < 2000) begin n++; tick(); end
      chk("R5 fast gates reverse", gate, 4'b1001);
      en = 1'b0; tick();
      chk("R1 coast from decay gates", gate, 0);
      chk("R1 coast from decay phase", phase, 0);
      trip = 1'b0;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule